// File: doc/BRIEF.md
# Exception Entry State Sequencer

This block performs the architectural state change that happens when a processor core takes an exception. The core presents an exception class code, a vector of cause bits, the address of the next instruction and the current machine state word, and pulses `entry_valid` for one cycle. One clock later the block shows the new fetch address, the saved return address, the saved state word, the data fault status word and the updated machine state word. It also raises a one-cycle `taken` pulse and a one-cycle `flush` pulse that invalidates translation caches.

External and timer-decrement requests that arrive while interrupts are masked are not taken. They are remembered as pending until a later entry of the same class is taken. A floating-point program exception is dropped when both floating-point exception mode bits are clear. A machine check that arrives while machine checks are disabled halts the block for good. The core uses the block as a single-step side unit: it issues one entry pulse per exception and then loads its registers from the outputs.

Machine state word bit positions used throughout: POW 18, ILE 16, EE 15, PR 14, FP 13, ME 12, FE0 11, SE 10, BE 9, FE1 8, IP 6, IR 5, DR 4, RI 1, LE 0.

Top module: `exc_entry_seq`

## Requirements
- R1: Exception class codes are reset 0x01, machine check 0x02, data fault 0x03, instruction fault 0x04, external 0x05, alignment 0x06, program 0x07, FP unavailable 0x08, decrementer 0x09, system call 0x0C, trace 0x0D and FP assist 0x0E. A taken entry sets `new_pc` to the code shifted left by 8. For a reset entry with the IP bit set, 0xFFC00 is added to the code before the shift. Any other code value is ignored.
- R2: `srr0` receives `nia` for reset, machine check, data fault, instruction fault, external, decrementer, system call, trace and FP assist. It receives `nia`-4 for alignment, program and FP unavailable.
- R3: `srr1` receives `msr_in` unchanged for every taken class except data fault, instruction fault and program. For those three, bits 31:16 are cleared first, and then any cause bits from R4 or R5 are ORed in.
- R4: The cause bit positions are: miss 0, protection 1, unsupported 2, direct-store 3, store 4, breakpoint 5, external-control 6, no-execute 7, guarded 8, FP 9, illegal 10, privileged 11, trap 12. On an instruction fault, `srr1` bit 30 is set if miss is set. Otherwise bit 28 is set if no-execute, guarded or direct-store is set. Otherwise bit 27 is set.
- R5: On a program entry, `srr1` bit 16 is set. One more bit is chosen in priority order: FP sets bit 20, illegal sets 19, privileged sets 18, trap sets 17. If the FP cause is set while FE0 and FE1 are both 0, the entry is dropped, and no output changes.
- R6: `dsisr` changes only on a taken data fault. It is built from zero as follows. Miss sets bit 30. Otherwise protection sets bit 27. Otherwise unsupported sets bit 31, and direct-store then also sets bit 26. Independently of these, store sets bit 25, breakpoint sets bit 22 and external-control sets bit 20.
- R7: On a taken entry, `msr_out` equals `msr_in` with POW, EE, PR, FP, FE0, SE, BE, FE1, IR, DR and RI cleared, and with LE taken from ILE. A machine check also clears ME.
- R8: An external or decrementer entry with EE=0 is not taken and sets `pend_ext` or `pend_dec`. A taken entry of that class clears its pending flag.
- R9: A machine check entry with ME=0 is not taken and sets `halted`. `halted` stays set until reset, and all later entries are ignored.
- R10: `taken` and `flush` pulse high for exactly one cycle, one clock after the `entry_valid` cycle of a taken entry. `new_pc`, `srr0`, `srr1` and `msr_out` update in that same cycle and otherwise hold.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| entry_valid | input | 1 | One-cycle exception entry request |
| exc_code | input | 8 | Exception class code |
| cause | input | 13 | Cause bit vector |
| nia | input | 32 | Next-instruction address |
| msr_in | input | 32 | Current machine state word |
| taken | output | 1 | Entry performed (pulse) |
| flush | output | 1 | Translation cache invalidate (pulse) |
| new_pc | output | 32 | Handler fetch address |
| srr0 | output | 32 | Saved return address |
| srr1 | output | 32 | Saved state word with cause bits |
| dsisr | output | 32 | Data fault status word |
| msr_out | output | 32 | Machine state word after entry |
| pend_ext | output | 1 | Deferred external request |
| pend_dec | output | 1 | Deferred decrementer request |
| halted | output | 1 | Fatal machine check seen |

## Verification
Every result of an entry pulse is due exactly one clock after the cycle in which `entry_valid` is high. The pending flags and `halted` are due at that same edge, and the pulses drop on the edge after that. The bench applies one stimulus per clock and advances a behavioural model at each rising edge. At the following falling edge it compares every output against the model, so every output is checked on every cycle, including idle, dropped and ignored cycles.

// File: rtl/exc_seq_pkg.sv
// Package: shared constants for the exception entry sequencer.
// Assumes a 32-bit machine state word and an 8-bit class code.
package exc_seq_pkg;

    localparam int WORD_W  = 32;
    localparam int CAUSE_W = 13;

    // Exception class codes; the handler vector is derived from them.
    localparam logic [7:0] EC_RESET  = 8'h01;
    localparam logic [7:0] EC_MCHK   = 8'h02;
    localparam logic [7:0] EC_DFAULT = 8'h03;
    localparam logic [7:0] EC_IFAULT = 8'h04;
    localparam logic [7:0] EC_EXT    = 8'h05;
    localparam logic [7:0] EC_ALIGN  = 8'h06;
    localparam logic [7:0] EC_PROG   = 8'h07;
    localparam logic [7:0] EC_FPUNAV = 8'h08;
    localparam logic [7:0] EC_DEC    = 8'h09;
    localparam logic [7:0] EC_SYSC   = 8'h0C;
    localparam logic [7:0] EC_TRACE  = 8'h0D;
    localparam logic [7:0] EC_FPAST  = 8'h0E;

    // Machine state word bit positions.
    localparam int SB_POW = 18;
    localparam int SB_ILE = 16;
    localparam int SB_EE  = 15;
    localparam int SB_PR  = 14;
    localparam int SB_FP  = 13;
    localparam int SB_ME  = 12;
    localparam int SB_FE0 = 11;
    localparam int SB_SE  = 10;
    localparam int SB_BE  = 9;
    localparam int SB_FE1 = 8;
    localparam int SB_IP  = 6;
    localparam int SB_IR  = 5;
    localparam int SB_DR  = 4;
    localparam int SB_RI  = 1;
    localparam int SB_LE  = 0;

    // Cause vector positions.
    localparam int CB_MISS   = 0;
    localparam int CB_PROT   = 1;
    localparam int CB_UNSUP  = 2;
    localparam int CB_DIRECT = 3;
    localparam int CB_STORE  = 4;
    localparam int CB_BRK    = 5;
    localparam int CB_XCTL   = 6;
    localparam int CB_NOEXEC = 7;
    localparam int CB_GUARD  = 8;
    localparam int CB_FPX    = 9;
    localparam int CB_ILL    = 10;
    localparam int CB_PRIV   = 11;
    localparam int CB_TRAP   = 12;

    localparam int          VEC_SHIFT  = 8;
    localparam logic [31:0] RESET_BIAS = 32'h000F_FC00;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_TAKE  = 2'd1,
        ACT_DEFER = 2'd2,
        ACT_FATAL = 2'd3
    } entry_act_e;

endpackage

// File: rtl/exc_classify.sv
// Decides what an entry request does: take, defer, drop or halt.
// It also picks the return-address flavour.
// Assumes the inputs are stable for the cycle in which they are evaluated.
module exc_classify
    import exc_seq_pkg::*;
(
    input  logic [7:0]         code,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [WORD_W-1:0]  msr,
    input  logic               halted,
    output entry_act_e         act,
    output logic               ret_cur
);

    // Classify the request by class code and gating bits.
    always_comb begin
        act     = ACT_NONE;
        ret_cur = 1'b0;
        if (!halted) begin
            unique case (code)
                EC_RESET, EC_DFAULT, EC_IFAULT,
                EC_SYSC, EC_TRACE, EC_FPAST: act = ACT_TAKE;
                EC_MCHK:  act = msr[SB_ME] ? ACT_TAKE : ACT_FATAL;
                EC_EXT, EC_DEC: act = msr[SB_EE] ? ACT_TAKE : ACT_DEFER;
                EC_ALIGN, EC_FPUNAV: begin
                    act     = ACT_TAKE;
                    ret_cur = 1'b1;
                end
                EC_PROG: begin
                    ret_cur = 1'b1;
                    if (cause[CB_FPX] && !msr[SB_FE0] && !msr[SB_FE1])
                        act = ACT_NONE;
                    else
                        act = ACT_TAKE;
                end
                default: act = ACT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/exc_cause_pack.sv
// Packs cause bits into the saved state word and the data fault status word.
// Assumes at most one program cause matters; a fixed priority picks it.
module exc_cause_pack
    import exc_seq_pkg::*;
(
    input  logic [7:0]         code,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [WORD_W-1:0]  msr,
    output logic [WORD_W-1:0]  saved_word,
    output logic [WORD_W-1:0]  fault_word
);

    localparam logic [WORD_W-1:0] LOW_HALF = WORD_W'(32'h0000_FFFF);

    logic [WORD_W-1:0] prog_bits;
    logic [WORD_W-1:0] ifault_bits;

    // Program cause encoding, highest priority first.
    always_comb begin
        prog_bits     = '0;
        prog_bits[16] = 1'b1;
        if (cause[CB_FPX])       prog_bits[20] = 1'b1;
        else if (cause[CB_ILL])  prog_bits[19] = 1'b1;
        else if (cause[CB_PRIV]) prog_bits[18] = 1'b1;
        else if (cause[CB_TRAP]) prog_bits[17] = 1'b1;
    end

    // Instruction fault cause encoding.
    always_comb begin
        ifault_bits = '0;
        if (cause[CB_MISS])
            ifault_bits[30] = 1'b1;
        else if (cause[CB_NOEXEC] || cause[CB_GUARD] || cause[CB_DIRECT])
            ifault_bits[28] = 1'b1;
        else
            ifault_bits[27] = 1'b1;
    end

    // Saved state word per class.
    always_comb begin
        unique case (code)
            EC_DFAULT: saved_word = msr & LOW_HALF;
            EC_IFAULT: saved_word = (msr & LOW_HALF) | ifault_bits;
            EC_PROG:   saved_word = (msr & LOW_HALF) | prog_bits;
            default:   saved_word = msr;
        endcase
    end

    // Data fault status word.
    always_comb begin
        fault_word = '0;
        if (cause[CB_MISS]) begin
            fault_word[30] = 1'b1;
        end else if (cause[CB_PROT]) begin
            fault_word[27] = 1'b1;
        end else if (cause[CB_UNSUP]) begin
            fault_word[31] = 1'b1;
            fault_word[26] = cause[CB_DIRECT];
        end
        fault_word[25] = cause[CB_STORE];
        fault_word[22] = cause[CB_BRK];
        fault_word[20] = cause[CB_XCTL];
    end

endmodule

// File: rtl/exc_state_update.sv
// Builds the machine state word loaded on exception entry.
// Assumes the caller flags machine check entries so ME can be cleared.
module exc_state_update
    import exc_seq_pkg::*;
(
    input  logic [WORD_W-1:0] msr,
    input  logic              is_mchk,
    output logic [WORD_W-1:0] msr_new
);

    localparam int N_CLR = 11;
    localparam int CLR_POS [N_CLR] = '{SB_POW, SB_EE, SB_PR, SB_FP, SB_FE0,
                                       SB_SE, SB_BE, SB_FE1, SB_IR, SB_DR,
                                       SB_RI};

    logic [WORD_W-1:0] clr_mask;

    // Build the clear mask from the position list.
    generate
        for (genvar b = 0; b < WORD_W; b++) begin : g_mask
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int k = 0; k < N_CLR; k++)
                    if (CLR_POS[k] == b) hit = 1'b1;
                clr_mask[b] = hit;
            end
        end
    endgenerate

    // Apply the clears, copy ILE to LE, and drop ME on machine check.
    always_comb begin
        msr_new        = msr & ~clr_mask;
        msr_new[SB_LE] = msr[SB_ILE];
        if (is_mchk) msr_new[SB_ME] = 1'b0;
    end

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer top. It registers every entry result one clock
// after the entry pulse, tracks deferred interrupts, and latches a fatal halt.
// Assumes entry_valid is a single-cycle pulse per request.
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CODE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               entry_valid,
    input  logic [CODE_W-1:0]  exc_code,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [ADDR_W-1:0]  nia,
    input  logic [WORD_W-1:0]  msr_in,
    output logic               taken,
    output logic               flush,
    output logic [ADDR_W-1:0]  new_pc,
    output logic [ADDR_W-1:0]  srr0,
    output logic [WORD_W-1:0]  srr1,
    output logic [WORD_W-1:0]  dsisr,
    output logic [WORD_W-1:0]  msr_out,
    output logic               pend_ext,
    output logic               pend_dec,
    output logic               halted
);

    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    logic [7:0]        code8;
    entry_act_e        act;
    logic              ret_cur;
    logic [WORD_W-1:0] saved_word;
    logic [WORD_W-1:0] fault_word;
    logic [WORD_W-1:0] msr_new;
    logic [ADDR_W-1:0] vec_base;
    logic [ADDR_W-1:0] vec_addr;
    logic [ADDR_W-1:0] ret_addr;

    assign code8 = 8'(exc_code);

    exc_classify u_classify (
        .code    (code8),
        .cause   (cause),
        .msr     (msr_in),
        .halted  (halted),
        .act     (act),
        .ret_cur (ret_cur)
    );

    exc_cause_pack u_pack (
        .code       (code8),
        .cause      (cause),
        .msr        (msr_in),
        .saved_word (saved_word),
        .fault_word (fault_word)
    );

    exc_state_update u_state (
        .msr     (msr_in),
        .is_mchk (code8 == EC_MCHK),
        .msr_new (msr_new)
    );

    // Handler vector, with the reset relocation bias when IP is set.
    always_comb begin
        vec_base = ADDR_W'(exc_code);
        if (code8 == EC_RESET && msr_in[SB_IP])
            vec_base = vec_base + ADDR_W'(RESET_BIAS);
        vec_addr = vec_base << VEC_SHIFT;
    end

    // Return address: current instruction or next instruction.
    assign ret_addr = ret_cur ? (nia - INSN_BYTES) : nia;

    // Register the entry results, the pending flags and the halt latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken    <= 1'b0;
            flush    <= 1'b0;
            new_pc   <= '0;
            srr0     <= '0;
            srr1     <= '0;
            dsisr    <= '0;
            msr_out  <= '0;
            pend_ext <= 1'b0;
            pend_dec <= 1'b0;
            halted   <= 1'b0;
        end else begin
            taken <= 1'b0;
            flush <= 1'b0;
            if (entry_valid) begin
                unique case (act)
                    ACT_TAKE: begin
                        taken   <= 1'b1;
                        flush   <= 1'b1;
                        new_pc  <= vec_addr;
                        srr0    <= ret_addr;
                        srr1    <= saved_word;
                        msr_out <= msr_new;
                        if (code8 == EC_DFAULT) dsisr    <= fault_word;
                        if (code8 == EC_EXT)    pend_ext <= 1'b0;
                        if (code8 == EC_DEC)    pend_dec <= 1'b0;
                    end
                    ACT_DEFER: begin
                        if (code8 == EC_EXT) pend_ext <= 1'b1;
                        else                 pend_dec <= 1'b1;
                    end
                    ACT_FATAL: halted <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/exc_entry_seq_chk.sv
// Checker for the exception entry sequencer; attached by bind below.
// Assumes synchronous active-low reset on the bound instance.
module exc_entry_seq_chk
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CODE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               entry_valid,
    input logic [CODE_W-1:0]  exc_code,
    input logic [WORD_W-1:0]  msr_in,
    input logic               taken,
    input logic               flush,
    input logic [ADDR_W-1:0]  new_pc,
    input logic [WORD_W-1:0]  msr_out,
    input logic               pend_ext,
    input logic               halted
);

    // R10
    taken_after_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> $past(entry_valid));

    // R10
    flush_with_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |=> (flush == taken));

    // R1
    vector_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (new_pc[VEC_SHIFT-1:0] == '0));

    // R7
    state_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (!msr_out[SB_EE] && !msr_out[SB_PR] && !msr_out[SB_IR]
                   && !msr_out[SB_DR] && !msr_out[SB_RI]));

    // R7
    le_from_ile_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (msr_out[SB_LE] == $past(msr_in[SB_ILE])));

    // R8
    ext_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && 8'(exc_code) == EC_EXT && !msr_in[SB_EE] && !halted)
        |=> (pend_ext && !taken));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9
    halt_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halted) |-> !taken);

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_valid (entry_valid),
    .exc_code    (exc_code),
    .msr_in      (msr_in),
    .taken       (taken),
    .flush       (flush),
    .new_pc      (new_pc),
    .msr_out     (msr_out),
    .pend_ext    (pend_ext),
    .halted      (halted)
);

// File: tb/tb_exc_entry_seq.sv
// Bench: a behavioural model is advanced at each rising edge and every
// output is compared at the following falling edge.
module tb_exc_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_valid = 1'b0;
    logic [7:0]  exc_code = '0;
    logic [12:0] cause = '0;
    logic [31:0] nia = '0;
    logic [31:0] msr_in = '0;
    logic        taken, flush, pend_ext, pend_dec, halted;
    logic [31:0] new_pc, srr0, srr1, dsisr, msr_out;

    int total = 0;
    int bad = 0;
    string srr1_tag = "R3";

    // model state
    logic        m_taken, m_flush, m_pe, m_pd, m_halt;
    logic [31:0] m_pc, m_srr0, m_srr1, m_dsisr, m_msr;

    always #5 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .entry_valid(entry_valid),
        .exc_code(exc_code), .cause(cause), .nia(nia), .msr_in(msr_in),
        .taken(taken), .flush(flush), .new_pc(new_pc), .srr0(srr0),
        .srr1(srr1), .dsisr(dsisr), .msr_out(msr_out),
        .pend_ext(pend_ext), .pend_dec(pend_dec), .halted(halted)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_taken = 0; m_flush = 0; m_pe = 0; m_pd = 0; m_halt = 0;
        m_pc = 0; m_srr0 = 0; m_srr1 = 0; m_dsisr = 0; m_msr = 0;
    endtask

    // Behavioural model of one rising edge.
    task automatic model_edge();
        bit go;
        bit cur;
        int c;
        logic [31:0] w;
        int clr [11] = '{18, 15, 14, 13, 11, 10, 9, 8, 5, 4, 1};
        m_taken = 0;
        m_flush = 0;
        if (!rst_n) begin
            model_clear();
            return;
        end
        if (!entry_valid || m_halt) return;
        c = int'(exc_code);
        go = 0;
        cur = (c == 6 || c == 7 || c == 8);
        if (c == 2) begin
            if (msr_in[12]) go = 1; else m_halt = 1;
        end else if (c == 5 || c == 9) begin
            if (msr_in[15]) go = 1;
            else if (c == 5) m_pe = 1;
            else m_pd = 1;
        end else if (c == 7) begin
            go = !(cause[9] && !msr_in[11] && !msr_in[8]);
        end else if (c == 1 || c == 3 || c == 4 || c == 6 || c == 8 ||
                     c == 12 || c == 13 || c == 14) begin
            go = 1;
        end
        if (!go) return;
        m_taken = 1;
        m_flush = 1;
        if (c == 1 && msr_in[6]) m_pc = (32'(c) + 32'hFFC00) * 256;
        else m_pc = 32'(c) * 256;
        m_srr0 = cur ? nia - 4 : nia;
        w = msr_in;
        if (c == 3 || c == 4 || c == 7) w = w & 32'h0000FFFF;
        if (c == 4) begin
            if (cause[0]) w[30] = 1;
            else if (cause[7] || cause[8] || cause[3]) w[28] = 1;
            else w[27] = 1;
        end
        if (c == 7) begin
            w[16] = 1;
            if (cause[9]) w[20] = 1;
            else if (cause[10]) w[19] = 1;
            else if (cause[11]) w[18] = 1;
            else if (cause[12]) w[17] = 1;
        end
        m_srr1 = w;
        if (c == 3) begin
            w = 0;
            if (cause[0]) w[30] = 1;
            else if (cause[1]) w[27] = 1;
            else if (cause[2]) begin w[31] = 1; w[26] = cause[3]; end
            if (cause[4]) w[25] = 1;
            if (cause[5]) w[22] = 1;
            if (cause[6]) w[20] = 1;
            m_dsisr = w;
        end
        w = msr_in;
        foreach (clr[k]) w[clr[k]] = 0;
        w[0] = msr_in[16];
        if (c == 2) w[12] = 0;
        m_msr = w;
        if (c == 5) m_pe = 0;
        if (c == 9) m_pd = 0;
    endtask

    task automatic compare_all();
        chk("R10", "taken", 32'(taken), 32'(m_taken));
        chk("R10", "flush", 32'(flush), 32'(m_flush));
        chk("R1", "new_pc", new_pc, m_pc);
        chk("R2", "srr0", srr0, m_srr0);
        chk(srr1_tag, "srr1", srr1, m_srr1);
        chk("R6", "dsisr", dsisr, m_dsisr);
        chk("R7", "msr_out", msr_out, m_msr);
        chk("R8", "pend_ext", 32'(pend_ext), 32'(m_pe));
        chk("R8", "pend_dec", 32'(pend_dec), 32'(m_pd));
        chk("R9", "halted", 32'(halted), 32'(m_halt));
    endtask

    // One clock: drive, advance the model at the edge, compare mid-cycle.
    task automatic step(bit v, logic [7:0] c, logic [12:0] cs,
                        logic [31:0] a, logic [31:0] m);
        entry_valid = v; exc_code = c; cause = cs; nia = a; msr_in = m;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        step(0, 8'h00, '0, 32'h0, 32'h0);
    endtask

    localparam logic [31:0] MSR_ALL = 32'h0005_FF73; // EE,ME,FE0,FE1,ILE,IP... set
    localparam logic [31:0] MSR_NOEE = MSR_ALL & ~32'h0000_8000;

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_clear();
        @(negedge clk);
        step(0, 8'h00, '0, 32'h0, 32'h0);
        step(0, 8'h00, '0, 32'h0, 32'h0);
        rst_n = 1'b1;
        // R11: reset state visible on idle cycle
        idle();

        // R1, R2, R3: system call, trace, assist keep the state word
        step(1, 8'h0C, '0, 32'h0000_1000, MSR_ALL);
        idle();
        step(1, 8'h0D, '0, 32'h0000_2004, 32'h0001_4021);
        step(1, 8'h0E, '0, 32'h0000_3008, 32'h0000_0000);
        idle();
        // R1: reset with and without IP
        step(1, 8'h01, '0, 32'h0000_4000, 32'h0000_0040);
        step(1, 8'h01, '0, 32'h0000_4000, 32'h0000_0000);

        // R6: data fault causes
        srr1_tag = "R3";
        step(1, 8'h03, 13'h0011, 32'hABCD_0000, 32'hFFFF_FFFF); // miss+store
        step(1, 8'h03, 13'h0003, 32'h0000_0010, MSR_ALL);       // miss wins over prot
        step(1, 8'h03, 13'h0002, 32'h0000_0020, MSR_ALL);       // prot only
        step(1, 8'h03, 13'h000C, 32'h0000_0030, MSR_ALL);       // unsup+direct
        step(1, 8'h03, 13'h0064, 32'h0000_0040, MSR_ALL);       // unsup,brk,xctl
        step(1, 8'h0C, 13'h1FFF, 32'h0000_0050, MSR_ALL);       // dsisr holds

        // R4: instruction fault causes
        srr1_tag = "R4";
        step(1, 8'h04, 13'h0001, 32'h0000_0100, 32'hFFFF_FFFF);
        step(1, 8'h04, 13'h0100, 32'h0000_0104, MSR_ALL);
        step(1, 8'h04, 13'h0008, 32'h0000_0108, MSR_ALL);
        step(1, 8'h04, 13'h0002, 32'h0000_010C, MSR_ALL);

        // R5: program causes and the dropped FP case
        srr1_tag = "R5";
        step(1, 8'h07, 13'h0400, 32'h0000_0200, 32'hFFFF_FFFF);
        step(1, 8'h07, 13'h1200, 32'h0000_0204, 32'h0000_0000); // dropped
        idle();
        step(1, 8'h07, 13'h0200, 32'h0000_0208, 32'h0000_0800); // FE0 set
        step(1, 8'h07, 13'h1800, 32'h0000_020C, MSR_ALL);       // priv over trap
        step(1, 8'h07, 13'h1000, 32'h0000_0210, MSR_ALL);
        step(1, 8'h07, 13'h0000, 32'h0000_0214, MSR_ALL);

        // R2: current-instruction classes
        srr1_tag = "R3";
        step(1, 8'h06, '0, 32'h0000_0300, MSR_ALL);
        step(1, 8'h08, '0, 32'h0000_0002, MSR_ALL);   // wraps below zero

        // R8: deferral and later take
        step(1, 8'h05, '0, 32'h0000_0400, MSR_NOEE);
        step(1, 8'h09, '0, 32'h0000_0404, MSR_NOEE);
        idle();
        step(1, 8'h05, '0, 32'h0000_0408, MSR_ALL);
        step(1, 8'h09, '0, 32'h0000_040C, MSR_ALL);

        // R1: unknown code ignored
        step(1, 8'h0A, 13'h1FFF, 32'h0000_0500, MSR_ALL);
        step(1, 8'hFF, 13'h1FFF, 32'h0000_0504, MSR_ALL);

        // R7: machine check with ME set clears ME
        step(1, 8'h02, '0, 32'h0000_0600, MSR_ALL);
        idle();
        // R9: fatal machine check then everything ignored
        step(1, 8'h02, '0, 32'h0000_0700, MSR_NOEE & ~32'h0000_1000);
        step(1, 8'h0C, '0, 32'h0000_0704, MSR_ALL);
        step(1, 8'h05, '0, 32'h0000_0708, MSR_NOEE);
        idle();
        idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule